// File: doc/BRIEF.md
# Threshold-Based Domain Speed Controller

This block chooses a two-level speed request, HIGH or LOW, for each of three execution clusters (integer, floating point, memory) and for the fetch front end. Each cluster lane adds up its issue-window occupancy over a window of sampled cycles. It takes the floor average with a shift and compares that average against a pair of programmable thresholds. The two thresholds give a hysteresis band. As an option, a cluster lane can discount its occupancy by the average number of pending dependencies that cross into or out of other clock domains. A queue that is full because it waits on another cluster then does not ask for more speed. The front-end lane uses the same rule on the average committed instructions per cycle. This lets the fetch domain slow down when the back end retires far below its peak.

All lanes share one window counter. The counter moves forward only on cycles where the sampling strobe is high, and every lane decides on the clock edge of the final sample of the window. When at least one request changes on that edge, a single-cycle change pulse follows. Voltage regulation and clock generation sit downstream of this block.

Top module: `speed_governor`

## Requirements
- R1: While reset is asserted and afterwards until the first decision, every speed request (`speedHigh` all ones, `feHigh`) is 1 (HIGH) and `chgPulse` is 0.
- R2: Each lane's metric is the floor of the sum of its values over 2^WIN_LOG2 sampled cycles (256 by default), divided by 2^WIN_LOG2. It is not the value of the last cycle.
- R3: A cycle with `sampleEn` low adds nothing to any sum and does not move the window forward. No decision can fall on such a cycle.
- R4: A lane in LOW (0) moves to HIGH (1) at a decision when its metric is strictly greater than its up threshold.
- R5: A lane in HIGH (1) moves to LOW (0) at a decision when its metric is strictly less than its down threshold.
- R6: In every other case the lane holds its mode. This includes a metric equal to either threshold and the case where the down threshold equals the up threshold.
- R7: Requests change only on the clock edge that takes the final sample of a window. Between decisions they are stable.
- R8: `chgPulse` is 1 for exactly the one cycle after a decision edge on which at least one request changed, and 0 at all other times.
- R9: With `depEn` at 1, a cluster metric is the average occupancy minus the average cross-domain dependency count, clamped at 0. With `depEn` at 0, `xDep` has no effect.
- R10: The front-end lane applies R4 to R6 to the average of `ipc`, using `feThrUp` and `feThrDn`, and drives `feHigh`.
- R11: The cluster lanes are independent. Index 0 is integer, 1 is floating point and 2 is memory. Each index uses only its own `occ`, `xDep`, `thrUp` and `thrDn` entries and drives only `speedHigh` at the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleEn | input | 1 | Sampling strobe; a high cycle is one sample |
| occ | input | NUM_CL x OCC_W | Issue-window occupancy per cluster |
| xDep | input | NUM_CL x DEP_W | Pending cross-domain dependencies per cluster |
| depEn | input | 1 | Use the dependency-discounted metric |
| thrUp | input | NUM_CL x OCC_W | Up threshold per cluster |
| thrDn | input | NUM_CL x OCC_W | Down threshold per cluster |
| ipc | input | IPC_W | Instructions committed this cycle |
| feThrUp | input | IPC_W | Front-end up threshold |
| feThrDn | input | IPC_W | Front-end down threshold |
| speedHigh | output | NUM_CL | Speed request per cluster, 1 = HIGH |
| feHigh | output | 1 | Front-end speed request, 1 = HIGH |
| chgPulse | output | 1 | One-cycle pulse after a decision that changed a request |

## Verification
A request is due on the rising edge that takes the 256th sampled cycle of a window, and `chgPulse` is due in the cycle that follows. The bench applies each window's inputs on a falling edge, counts exactly 256 rising edges with the strobe high, and samples on the next falling edge. That falling edge lies inside the one cycle in which the pulse is valid. One directed case looks one cycle before the boundary to confirm that nothing has changed yet, and one cycle after it to confirm that the pulse has already dropped. The gating case adds idle cycles in the middle of a window, so a decision that came early or late would show up at the checked edge.

// File: rtl/gov_pkg.sv
package gov_pkg;

  // Strobes from the window control to every lane datapath.
  typedef struct packed {
    logic accEn;   // this cycle is a sample
    logic winEnd;  // this sample closes the window; decide on this edge
  } govStrb_t;

endpackage

// File: rtl/gov_ctrl.sv
module gov_ctrl
  import gov_pkg::*;
#(
  parameter int WIN_LOG2 = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     sampleEn,
  output govStrb_t strb
);

  localparam logic [WIN_LOG2-1:0] LAST_SAMPLE = '1;

  logic [WIN_LOG2-1:0] sampCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampCnt <= '0;
    end else if (sampleEn) begin
      sampCnt <= sampCnt + 1'b1;
    end
  end

  always_comb begin
    strb.accEn  = sampleEn;
    strb.winEnd = sampleEn && (sampCnt == LAST_SAMPLE);
  end

endmodule

// File: rtl/gov_lane.sv
module gov_lane
  import gov_pkg::*;
#(
  parameter int VAL_W    = 6,
  parameter int DEP_W    = 6,
  parameter int WIN_LOG2 = 8,
  parameter bit HAS_DEP  = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  govStrb_t         strb,
  input  logic [VAL_W-1:0] val,
  input  logic [DEP_W-1:0] dep,
  input  logic             depEn,
  output logic [VAL_W-1:0] metric
);

  localparam int SUM_W  = VAL_W + WIN_LOG2;
  localparam int DSUM_W = DEP_W + WIN_LOG2;
  localparam int CMP_W  = (VAL_W > DEP_W) ? VAL_W : DEP_W;

  logic [SUM_W-1:0] valSum;
  logic [SUM_W-1:0] valNext;
  logic [VAL_W-1:0] avgVal;

  // The sum includes the current sample, so the average is final on the
  // edge that closes the window.
  assign valNext = valSum + SUM_W'(val);
  assign avgVal  = valNext[SUM_W-1:WIN_LOG2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valSum <= '0;
    end else if (strb.accEn) begin
      valSum <= strb.winEnd ? '0 : valNext;
    end
  end

  generate
    if (HAS_DEP) begin : gDep
      logic [DSUM_W-1:0] depSum;
      logic [DSUM_W-1:0] depNext;
      logic [DEP_W-1:0]  avgDep;
      logic [CMP_W-1:0]  diff;

      assign depNext = depSum + DSUM_W'(dep);
      assign avgDep  = depNext[DSUM_W-1:WIN_LOG2];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          depSum <= '0;
        end else if (strb.accEn) begin
          depSum <= strb.winEnd ? '0 : depNext;
        end
      end

      always_comb begin
        diff = CMP_W'(avgVal) - CMP_W'(avgDep);
        if (!depEn) begin
          metric = avgVal;
        end else if (CMP_W'(avgDep) >= CMP_W'(avgVal)) begin
          metric = '0;
        end else begin
          metric = VAL_W'(diff);
        end
      end
    end else begin : gNoDep
      logic unusedDep;
      assign unusedDep = ^{dep, depEn};
      assign metric    = avgVal;
    end
  endgenerate

endmodule

// File: rtl/gov_hyst.sv
module gov_hyst #(
  parameter int M_W = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           decide,
  input  logic [M_W-1:0] metric,
  input  logic [M_W-1:0] thrUp,
  input  logic [M_W-1:0] thrDn,
  output logic           isHigh,
  output logic           changeNow
);

  logic nextHigh;

  always_comb begin
    if (isHigh) begin
      nextHigh = (metric >= thrDn);
    end else begin
      nextHigh = (metric > thrUp);
    end
    changeNow = decide && (nextHigh != isHigh);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isHigh <= 1'b1;
    end else if (decide) begin
      isHigh <= nextHigh;
    end
  end

endmodule

// File: rtl/speed_governor.sv
module speed_governor
  import gov_pkg::*;
#(
  parameter int NUM_CL   = 3,
  parameter int OCC_W    = 6,
  parameter int DEP_W    = 6,
  parameter int IPC_W    = 3,
  parameter int WIN_LOG2 = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         sampleEn,
  input  logic [NUM_CL-1:0][OCC_W-1:0] occ,
  input  logic [NUM_CL-1:0][DEP_W-1:0] xDep,
  input  logic                         depEn,
  input  logic [NUM_CL-1:0][OCC_W-1:0] thrUp,
  input  logic [NUM_CL-1:0][OCC_W-1:0] thrDn,
  input  logic [IPC_W-1:0]             ipc,
  input  logic [IPC_W-1:0]             feThrUp,
  input  logic [IPC_W-1:0]             feThrDn,
  output logic [NUM_CL-1:0]            speedHigh,
  output logic                         feHigh,
  output logic                         chgPulse
);

  localparam int NUM_LANES = NUM_CL + 1;

  govStrb_t                    strb;
  logic [NUM_CL-1:0][OCC_W-1:0] clMetric;
  logic [IPC_W-1:0]            feMetric;
  logic [NUM_LANES-1:0]        laneChange;

  gov_ctrl #(.WIN_LOG2(WIN_LOG2)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .sampleEn(sampleEn),
    .strb    (strb)
  );

  generate
    for (genvar c = 0; c < NUM_CL; c++) begin : gCluster
      gov_lane #(
        .VAL_W   (OCC_W),
        .DEP_W   (DEP_W),
        .WIN_LOG2(WIN_LOG2),
        .HAS_DEP (1'b1)
      ) uLane (
        .clk   (clk),
        .rstN  (rstN),
        .strb  (strb),
        .val   (occ[c]),
        .dep   (xDep[c]),
        .depEn (depEn),
        .metric(clMetric[c])
      );

      gov_hyst #(.M_W(OCC_W)) uHyst (
        .clk      (clk),
        .rstN     (rstN),
        .decide   (strb.winEnd),
        .metric   (clMetric[c]),
        .thrUp    (thrUp[c]),
        .thrDn    (thrDn[c]),
        .isHigh   (speedHigh[c]),
        .changeNow(laneChange[c])
      );
    end
  endgenerate

  gov_lane #(
    .VAL_W   (IPC_W),
    .DEP_W   (DEP_W),
    .WIN_LOG2(WIN_LOG2),
    .HAS_DEP (1'b0)
  ) uFeLane (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .val   (ipc),
    .dep   ('0),
    .depEn (1'b0),
    .metric(feMetric)
  );

  gov_hyst #(.M_W(IPC_W)) uFeHyst (
    .clk      (clk),
    .rstN     (rstN),
    .decide   (strb.winEnd),
    .metric   (feMetric),
    .thrUp    (feThrUp),
    .thrDn    (feThrDn),
    .isHigh   (feHigh),
    .changeNow(laneChange[NUM_CL])
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chgPulse <= 1'b0;
    end else begin
      chgPulse <= |laneChange;
    end
  end

endmodule

// File: rtl/gov_checker.sv
module gov_checker #(
  parameter int NUM_CL = 3,
  parameter int OCC_W  = 6,
  parameter int IPC_W  = 3
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         sampleEn,
  input logic                         winEnd,
  input logic [NUM_CL-1:0]            speedHigh,
  input logic                         feHigh,
  input logic                         chgPulse,
  input logic [NUM_CL-1:0][OCC_W-1:0] clMetric,
  input logic [NUM_CL-1:0][OCC_W-1:0] thrUp,
  input logic [NUM_CL-1:0][OCC_W-1:0] thrDn,
  input logic [IPC_W-1:0]             feMetric,
  input logic [IPC_W-1:0]             feThrUp,
  input logic [IPC_W-1:0]             feThrDn
);

  AST_RESET_HIGH: assert property (@(posedge clk)
    !rstN |=> ((&speedHigh) && feHigh && !chgPulse)); // R1

  AST_IDLE_NO_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |-> !winEnd); // R3

  AST_HOLD_OFF_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    !winEnd |=> ($stable(speedHigh) && $stable(feHigh))); // R7

  AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    chgPulse == ({speedHigh, feHigh} != $past({speedHigh, feHigh}))); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    chgPulse |=> !chgPulse); // R8

  AST_FE_DROP_BELOW_DN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(feHigh) |-> $past(feMetric < feThrDn)); // R10

  AST_FE_RAISE_ABOVE_UP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(feHigh) |-> $past(feMetric > feThrUp)); // R10

  generate
    for (genvar c = 0; c < NUM_CL; c++) begin : gClChk
      AST_RAISE_ABOVE_UP: assert property (@(posedge clk) disable iff (!rstN)
        $rose(speedHigh[c]) |-> $past(clMetric[c] > thrUp[c])); // R4

      AST_DROP_BELOW_DN: assert property (@(posedge clk) disable iff (!rstN)
        $fell(speedHigh[c]) |-> $past(clMetric[c] < thrDn[c])); // R5
    end
  endgenerate

endmodule

bind speed_governor gov_checker #(
  .NUM_CL(NUM_CL),
  .OCC_W (OCC_W),
  .IPC_W (IPC_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .sampleEn (sampleEn),
  .winEnd   (strb.winEnd),
  .speedHigh(speedHigh),
  .feHigh   (feHigh),
  .chgPulse (chgPulse),
  .clMetric (clMetric),
  .thrUp    (thrUp),
  .thrDn    (thrDn),
  .feMetric (feMetric),
  .feThrUp  (feThrUp),
  .feThrDn  (feThrDn)
);

// File: tb/tb_speed_governor.sv
module tb_speed_governor;

  localparam int CLK_P    = 10;
  localparam int NUM_CL   = 3;
  localparam int OCC_W    = 6;
  localparam int DEP_W    = 6;
  localparam int IPC_W    = 3;
  localparam int WIN_LOG2 = 8;
  localparam int WIN      = 1 << WIN_LOG2;

  typedef struct packed {
    logic [2:0][5:0] occ;    // {mem, fp, int}
    logic [2:0][5:0] dep;    // {mem, fp, int}
    logic            depEn;
    logic [2:0]      ipc;
    logic [2:0]      expCl;  // {mem, fp, int}
    logic            expFe;
    logic            expChg;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{occ:{6'd30,6'd20,6'd30}, dep:'0,                  depEn:1'b0, ipc:3'd4, expCl:3'b111, expFe:1'b1, expChg:1'b0},
    '{occ:{6'd15,6'd9, 6'd19}, dep:'0,                  depEn:1'b0, ipc:3'd1, expCl:3'b000, expFe:1'b0, expChg:1'b1},
    '{occ:{6'd48,6'd30,6'd40}, dep:'0,                  depEn:1'b0, ipc:3'd3, expCl:3'b000, expFe:1'b0, expChg:1'b0},
    '{occ:{6'd60,6'd10,6'd41}, dep:'0,                  depEn:1'b0, ipc:3'd4, expCl:3'b101, expFe:1'b1, expChg:1'b1},
    '{occ:{6'd16,6'd31,6'd20}, dep:'0,                  depEn:1'b0, ipc:3'd2, expCl:3'b111, expFe:1'b1, expChg:1'b1},
    '{occ:{6'd50,6'd50,6'd50}, dep:{6'd40,6'd45,6'd35}, depEn:1'b1, ipc:3'd4, expCl:3'b000, expFe:1'b1, expChg:1'b1},
    '{occ:{6'd50,6'd50,6'd50}, dep:{6'd40,6'd45,6'd35}, depEn:1'b0, ipc:3'd4, expCl:3'b111, expFe:1'b1, expChg:1'b1},
    '{occ:{6'd5, 6'd5, 6'd5 }, dep:{6'd6, 6'd31,6'd20}, depEn:1'b1, ipc:3'd0, expCl:3'b000, expFe:1'b0, expChg:1'b1},
    '{occ:{6'd63,6'd63,6'd63}, dep:'0,                  depEn:1'b1, ipc:3'd4, expCl:3'b111, expFe:1'b1, expChg:1'b1}
  };

  logic                         clk = 1'b0;
  logic                         rstN;
  logic                         sampleEn;
  logic [NUM_CL-1:0][OCC_W-1:0] occ;
  logic [NUM_CL-1:0][DEP_W-1:0] xDep;
  logic                         depEn;
  logic [NUM_CL-1:0][OCC_W-1:0] thrUp;
  logic [NUM_CL-1:0][OCC_W-1:0] thrDn;
  logic [IPC_W-1:0]             ipc;
  logic [IPC_W-1:0]             feThrUp;
  logic [IPC_W-1:0]             feThrDn;
  logic [NUM_CL-1:0]            speedHigh;
  logic                         feHigh;
  logic                         chgPulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  speed_governor #(
    .NUM_CL(NUM_CL), .OCC_W(OCC_W), .DEP_W(DEP_W),
    .IPC_W(IPC_W), .WIN_LOG2(WIN_LOG2)
  ) dut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .occ(occ), .xDep(xDep),
    .depEn(depEn), .thrUp(thrUp), .thrDn(thrDn), .ipc(ipc),
    .feThrUp(feThrUp), .feThrDn(feThrDn), .speedHigh(speedHigh),
    .feHigh(feHigh), .chgPulse(chgPulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic [2:0] eCl, input logic eFe, input logic eChg);
    check({tag, " speedHigh"}, 32'(speedHigh), 32'(eCl));
    check({tag, " feHigh"},    32'(feHigh),    32'(eFe));
    check({tag, " chgPulse"},  32'(chgPulse),  32'(eChg));
  endtask

  // Starts on a falling edge; ends on the falling edge after the decision edge.
  task automatic runWin();
    repeat (WIN) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    sampleEn = 1'b0;
    occ      = '0;
    xDep     = '0;
    depEn    = 1'b0;
    ipc      = '0;
    thrUp[0] = 6'd40; thrDn[0] = 6'd20;
    thrUp[1] = 6'd30; thrDn[1] = 6'd10;
    thrUp[2] = 6'd48; thrDn[2] = 6'd16;
    feThrUp  = 3'd3;  feThrDn  = 3'd2;

    repeat (3) @(posedge clk);
    @(negedge clk);
    checkAll("R1 during reset", 3'b111, 1'b1, 1'b0);
    rstN     = 1'b1;
    sampleEn = 1'b1;
    checkAll("R1 after release", 3'b111, 1'b1, 1'b0);

    // Table: R4 R5 R6 R9 R10 R11, one window per vector.
    for (int i = 0; i < NVEC; i++) begin
      occ   = VEC[i].occ;
      xDep  = VEC[i].dep;
      depEn = VEC[i].depEn;
      ipc   = VEC[i].ipc;
      runWin();
      checkAll($sformatf("R4 R5 R6 R9 R10 R11 vector %0d", i),
               VEC[i].expCl, VEC[i].expFe, VEC[i].expChg);
    end

    // R2: averaging; alternating 0/40 averages 20 (hold), 0/38 averages 19 (drop).
    depEn = 1'b0;
    xDep  = '0;
    occ[1] = 6'd25; occ[2] = 6'd30; ipc = 3'd2;
    for (int k = 0; k < WIN; k++) begin
      occ[0] = k[0] ? 6'd40 : 6'd0;
      @(posedge clk); @(negedge clk);
    end
    checkAll("R2 average equals down threshold", 3'b111, 1'b1, 1'b0);
    for (int k = 0; k < WIN; k++) begin
      occ[0] = k[0] ? 6'd38 : 6'd0;
      @(posedge clk); @(negedge clk);
    end
    checkAll("R2 average below down threshold", 3'b110, 1'b1, 1'b1);

    // R3: idle cycles inside a window are neither summed nor counted.
    occ[0] = 6'd45;
    repeat (WIN/2) @(posedge clk);
    @(negedge clk);
    sampleEn = 1'b0;
    occ[0]   = 6'd0;
    repeat (50) @(posedge clk);
    @(negedge clk);
    checkAll("R3 idle stretch no decision", 3'b110, 1'b1, 1'b0);
    sampleEn = 1'b1;
    occ[0]   = 6'd45;
    repeat (WIN/2) @(posedge clk);
    @(negedge clk);
    checkAll("R3 window closes after 256 samples", 3'b111, 1'b1, 1'b1);

    // R6: equal thresholds on the integer lane.
    thrUp[0] = 6'd25; thrDn[0] = 6'd25;
    occ[0] = 6'd25; runWin(); checkAll("R6 equal thr hold high", 3'b111, 1'b1, 1'b0);
    occ[0] = 6'd24; runWin(); checkAll("R5 equal thr drop",      3'b110, 1'b1, 1'b1);
    occ[0] = 6'd25; runWin(); checkAll("R6 equal thr hold low",  3'b110, 1'b1, 1'b0);
    occ[0] = 6'd26; runWin(); checkAll("R4 equal thr raise",     3'b111, 1'b1, 1'b1);

    // R7 R8: exact decision edge and pulse width.
    occ[0] = 6'd10;
    repeat (WIN-1) @(posedge clk);
    @(negedge clk);
    checkAll("R7 one cycle before boundary", 3'b111, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    checkAll("R7 R8 at boundary", 3'b110, 1'b1, 1'b1);
    @(posedge clk); @(negedge clk);
    checkAll("R8 pulse dropped after one cycle", 3'b110, 1'b1, 1'b0);
    repeat (WIN-1) @(posedge clk);
    @(negedge clk);
    checkAll("R6 low held next window", 3'b110, 1'b1, 1'b0);

    // R11: only the floating point lane sees a low occupancy.
    occ[1] = 6'd5;
    runWin();
    checkAll("R11 fp lane alone drops", 3'b100, 1'b1, 1'b1);

    // R1: reset in the middle of a window returns to HIGH.
    repeat (17) @(posedge clk);
    @(negedge clk);
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    checkAll("R1 mid-run reset", 3'b111, 1'b1, 1'b0);
    rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule